// File: doc/BRIEF.md
# Chunked Configuration Port Writer

This block moves a stored configuration image from a word-addressed source memory into a configuration port, one staging-buffer load at a time. A command supplies the source address of the first word and the image length in words. The block then repeatedly copies the next run of source words into a local staging buffer, starting each time at buffer slot 0. It then asks an external port engine to send that run from the buffer. The request length is the buffer depth, or the smaller count still left on the last pass.

The next buffer load begins only after the port engine acknowledges the current transfer, so the buffer is never rewritten while it is being drained. On the last, shorter pass only the words still owed are read, so no source read ever falls outside the image. A command of zero words finishes at once without touching either memory or the engine. The source read latency is a parameter, so the same block can sit behind a plain registered memory or a deeper pipelined one.

Top module: `cfg_chunk_writer`

## Requirements
- R1: After reset, `busy`, `done`, `xfer_req`, `src_rd_en` and `buf_wr_en` are all low.
- R2: Every pass writes staging slots in ascending order from slot 0. Slot k of pass n receives the source word at address `cmd_addr + n*BUF_DEPTH + k`. Every transfer therefore draws on the buffer from slot 0.
- R3: Each transfer request carries `xfer_len` equal to the smaller of the words still owed and `BUF_DEPTH`, and never zero.
- R4: Each acknowledged transfer lowers the words still owed by its length. The command ends when none are left, after exactly ceil(`cmd_len`/`BUF_DEPTH`) transfers.
- R5: `xfer_req` stays high with an unchanged `xfer_len` until the cycle in which `xfer_done` is sampled high. `xfer_done` has no effect while no request is pending.
- R6: While a transfer request is pending, the block issues no source read and no staging write.
- R7: A command with `cmd_len` = 0 raises `done` (with `busy` high) in the cycle after it is accepted, with no read and no transfer.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle. A `cmd_start` seen while busy is ignored and does not change the running command.
- R9: Source reads stay within `cmd_addr` to `cmd_addr + cmd_len - 1`, and exactly `cmd_len` reads are made per command.
- R10: `done` is a one-cycle pulse in the last busy cycle. In the following cycle both `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a command (accepted only when idle) |
| cmd_addr | input | ADDR_W | Source address of the first image word |
| cmd_len | input | LEN_W | Image length in words |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command completion |
| src_rd_en | output | 1 | Source memory read strobe |
| src_rd_addr | output | ADDR_W | Source memory read address |
| src_rd_data | input | DATA_W | Read data, valid RD_LAT cycles after the strobe |
| buf_wr_en | output | 1 | Staging buffer write strobe |
| buf_wr_addr | output | $clog2(BUF_DEPTH) | Staging buffer slot |
| buf_wr_data | output | DATA_W | Staging buffer write data |
| xfer_req | output | 1 | Port transfer request, held until acknowledged |
| xfer_len | output | $clog2(BUF_DEPTH+1) | Words to send from slot 0 |
| xfer_done | input | 1 | Port engine acknowledge |

## Verification
The bench builds the block with a 16-word staging buffer, a two-cycle read latency, 16-bit addresses and 12-bit lengths. The small buffer lets random lengths up to 70 words span up to five passes and land on exact multiples, one-over and one-under lengths within a few hundred cycles. The two-cycle latency exercises the deeper pipeline variant, where fill completion and the final read are separated in time. A port-engine model with random acknowledge delay stretches the hold window that the transfer checks rely on.

// File: rtl/cfg_chunk_pkg.sv
package cfg_chunk_pkg;

   // Sequencer phases for one command
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LOAD   = 3'd1,
      PH_FILL   = 3'd2,
      PH_SEND   = 3'd3,
      PH_FINISH = 3'd4
   } phase_t;

endpackage

// File: rtl/cfg_chunk_fill.sv
module cfg_chunk_fill #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int BUF_DEPTH = 512,
   parameter int RD_LAT    = 1,
   localparam int BUF_AW   = $clog2(BUF_DEPTH),
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_base,
   input  logic [CNT_W-1:0]  go_count,
   output logic              fill_done,
   output logic              src_rd_en,
   output logic [ADDR_W-1:0] src_rd_addr,
   input  logic [DATA_W-1:0] src_rd_data,
   output logic              buf_wr_en,
   output logic [BUF_AW-1:0] buf_wr_addr,
   output logic [DATA_W-1:0] buf_wr_data
);

   initial begin
      assert (RD_LAT >= 1) else $error("RD_LAT must be at least 1");
      assert (BUF_DEPTH >= 2) else $error("BUF_DEPTH must be at least 2");
   end

   logic              issuing_q;
   logic [BUF_AW-1:0] slot_q;
   logic [BUF_AW-1:0] last_q;
   logic [ADDR_W-1:0] base_q;
   logic              is_last;

   assign is_last = (slot_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issuing_q <= 1'b0;
         slot_q    <= '0;
         last_q    <= '0;
         base_q    <= '0;
      end else if (go) begin
         issuing_q <= 1'b1;
         slot_q    <= '0;
         last_q    <= BUF_AW'(go_count - 1'b1);
         base_q    <= go_base;
      end else if (issuing_q) begin
         slot_q <= slot_q + 1'b1;
         if (is_last) issuing_q <= 1'b0;
      end
   end

   assign src_rd_en   = issuing_q;
   assign src_rd_addr = base_q + ADDR_W'(slot_q);

   // Return pipeline: tracks slot and last flag alongside outstanding reads
   logic              ret_v;
   logic              ret_last;
   logic [BUF_AW-1:0] ret_slot;

   generate
      if (RD_LAT == 1) begin : g_lat1
         logic              v_q;
         logic              l_q;
         logic [BUF_AW-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               l_q <= 1'b0;
               s_q <= '0;
            end else begin
               v_q <= issuing_q;
               l_q <= issuing_q & is_last;
               s_q <= slot_q;
            end
         end
         assign ret_v    = v_q;
         assign ret_last = l_q;
         assign ret_slot = s_q;
      end else begin : g_latn
         logic [RD_LAT-1:0] v_q;
         logic [RD_LAT-1:0] l_q;
         logic [BUF_AW-1:0] s_q [RD_LAT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= '0;
               l_q <= '0;
               for (int s = 0; s < RD_LAT; s++) s_q[s] <= '0;
            end else begin
               v_q[0] <= issuing_q;
               l_q[0] <= issuing_q & is_last;
               s_q[0] <= slot_q;
               for (int s = 1; s < RD_LAT; s++) begin
                  v_q[s] <= v_q[s-1];
                  l_q[s] <= l_q[s-1];
                  s_q[s] <= s_q[s-1];
               end
            end
         end
         assign ret_v    = v_q[RD_LAT-1];
         assign ret_last = l_q[RD_LAT-1];
         assign ret_slot = s_q[RD_LAT-1];
      end
   endgenerate

   assign buf_wr_en   = ret_v;
   assign buf_wr_addr = ret_slot;
   assign buf_wr_data = src_rd_data;
   assign fill_done   = ret_v & ret_last;

   // R2: writes of one pass climb one slot at a time
   assert_wr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr_en && !fill_done) |=> (buf_wr_en && buf_wr_addr == $past(buf_wr_addr) + 1'b1));

   // R2: each pass begins at slot 0
   assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_wr_en) |-> (buf_wr_addr == '0));

   // R9: no read is issued in the cycle a new pass is launched
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !src_rd_en && !buf_wr_en);

endmodule

// File: rtl/cfg_chunk_seq.sv
module cfg_chunk_seq
   import cfg_chunk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 24,
   parameter int BUF_DEPTH = 512,
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              fill_go,
   output logic [ADDR_W-1:0] fill_base,
   output logic [CNT_W-1:0]  fill_count,
   input  logic              fill_done,
   output logic              xfer_req,
   output logic [CNT_W-1:0]  xfer_len,
   input  logic              xfer_done,
   output logic              busy,
   output logic              done
);

   initial begin
      assert (LEN_W >= CNT_W) else $error("LEN_W must cover BUF_DEPTH");
   end

   phase_t            phase_q;
   logic [LEN_W-1:0]  owed_q;
   logic [ADDR_W-1:0] next_q;
   logic [CNT_W-1:0]  chunk;
   logic [LEN_W-1:0]  owed_after;

   assign chunk      = (owed_q < LEN_W'(BUF_DEPTH)) ? CNT_W'(owed_q) : CNT_W'(BUF_DEPTH);
   assign owed_after = owed_q - LEN_W'(chunk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         owed_q  <= '0;
         next_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (cmd_start) begin
               owed_q  <= cmd_len;
               next_q  <= cmd_addr;
               phase_q <= (cmd_len == '0) ? PH_FINISH : PH_LOAD;
            end
            PH_LOAD: phase_q <= PH_FILL;
            PH_FILL: if (fill_done) phase_q <= PH_SEND;
            PH_SEND: if (xfer_done) begin
               owed_q  <= owed_after;
               next_q  <= next_q + ADDR_W'(chunk);
               phase_q <= (owed_after == '0) ? PH_FINISH : PH_LOAD;
            end
            PH_FINISH: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign fill_go    = (phase_q == PH_LOAD);
   assign fill_base  = next_q;
   assign fill_count = chunk;
   assign xfer_req   = (phase_q == PH_SEND);
   assign xfer_len   = chunk;
   assign busy       = (phase_q != PH_IDLE);
   assign done       = (phase_q == PH_FINISH);

   // R3: requested length is nonzero and no larger than the buffer
   assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (xfer_len != '0 && xfer_len <= CNT_W'(BUF_DEPTH)));

   // R5: request holds with the same length until acknowledged
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_len)));

   // R8: owed count moves only on an acknowledged transfer
   assert_owed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(xfer_req && xfer_done)) |=> $stable(owed_q));

   // R7: empty command completes in the next cycle
   assert_zero_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_start && cmd_len == '0) |=> (done && busy));

   // R10: done is a single pulse that ends the busy window
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

endmodule

// File: rtl/cfg_chunk_writer.sv
module cfg_chunk_writer #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 24,
   parameter int BUF_DEPTH = 512,
   parameter int RD_LAT    = 1,
   localparam int BUF_AW   = $clog2(BUF_DEPTH),
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              busy,
   output logic              done,
   output logic              src_rd_en,
   output logic [ADDR_W-1:0] src_rd_addr,
   input  logic [DATA_W-1:0] src_rd_data,
   output logic              buf_wr_en,
   output logic [BUF_AW-1:0] buf_wr_addr,
   output logic [DATA_W-1:0] buf_wr_data,
   output logic              xfer_req,
   output logic [CNT_W-1:0]  xfer_len,
   input  logic              xfer_done
);

   logic              fill_go;
   logic [ADDR_W-1:0] fill_base;
   logic [CNT_W-1:0]  fill_count;
   logic              fill_done;

   cfg_chunk_seq #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .BUF_DEPTH (BUF_DEPTH)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .cmd_addr   (cmd_addr),
      .cmd_len    (cmd_len),
      .fill_go    (fill_go),
      .fill_base  (fill_base),
      .fill_count (fill_count),
      .fill_done  (fill_done),
      .xfer_req   (xfer_req),
      .xfer_len   (xfer_len),
      .xfer_done  (xfer_done),
      .busy       (busy),
      .done       (done)
   );

   cfg_chunk_fill #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .BUF_DEPTH (BUF_DEPTH),
      .RD_LAT    (RD_LAT)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (fill_go),
      .go_base     (fill_base),
      .go_count    (fill_count),
      .fill_done   (fill_done),
      .src_rd_en   (src_rd_en),
      .src_rd_addr (src_rd_addr),
      .src_rd_data (src_rd_data),
      .buf_wr_en   (buf_wr_en),
      .buf_wr_addr (buf_wr_addr),
      .buf_wr_data (buf_wr_data)
   );

   // R6: the buffer is left alone while the port engine drains it
   assert_quiet_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (!src_rd_en && !buf_wr_en));

   // R8: memory activity only inside a command
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!src_rd_en && !buf_wr_en && !xfer_req));

endmodule

// File: tb/cfg_chunk_writer_bench.sv
module cfg_chunk_writer_bench;

   localparam int DW  = 32;
   localparam int AW  = 16;
   localparam int LW  = 12;
   localparam int D   = 16;
   localparam int RL  = 2;
   localparam int BAW = $clog2(D);
   localparam int CW  = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic           cmd_start = 1'b0;
   logic [AW-1:0]  cmd_addr = '0;
   logic [LW-1:0]  cmd_len = '0;
   logic           busy, done;
   logic           src_rd_en;
   logic [AW-1:0]  src_rd_addr;
   logic [DW-1:0]  src_rd_data;
   logic           buf_wr_en;
   logic [BAW-1:0] buf_wr_addr;
   logic [DW-1:0]  buf_wr_data;
   logic           xfer_req;
   logic [CW-1:0]  xfer_len;
   logic           xfer_done = 1'b0;

   cfg_chunk_writer #(
      .DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .BUF_DEPTH(D), .RD_LAT(RL)
   ) u_cfg_chunk_writer (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .busy(busy), .done(done),
      .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
      .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
      .xfer_req(xfer_req), .xfer_len(xfer_len), .xfer_done(xfer_done)
   );

   int checks = 0;
   int failures = 0;

   function automatic logic [DW-1:0] pat(input int a);
      return (32'h9E3779B1 * a) ^ 32'h0F1E2D3C;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Source memory model with RL-cycle read latency
   logic [DW-1:0] mq [RL];
   always @(posedge clk) begin
      mq[0] <= pat(int'(src_rd_addr));
      for (int s = 1; s < RL; s++) mq[s] <= mq[s-1];
   end
   assign src_rd_data = mq[RL-1];

   // Staging buffer model
   logic [DW-1:0] sbuf [D];
   always @(posedge clk) if (buf_wr_en) sbuf[buf_wr_addr] <= buf_wr_data;

   // Per-command expectations
   int  lo_addr, hi_addr, exp_rem, exp_base, n_reads, n_xfers, wr_next, cur_chunk, wait_cnt;
   bit  in_xfer, bad_rd, bad_gap, bad_hold, bad_ord;

   // Port engine model and cycle monitor
   always @(negedge clk) begin
      if (src_rd_en) begin
         n_reads++;
         if (int'(src_rd_addr) < lo_addr || int'(src_rd_addr) > hi_addr) bad_rd = 1'b1;
         if (in_xfer) bad_gap = 1'b1;
      end
      if (buf_wr_en) begin
         if (in_xfer) bad_gap = 1'b1;
         if (int'(buf_wr_addr) != wr_next) bad_ord = 1'b1;
         wr_next++;
      end
      if (xfer_done) begin
         xfer_done = 1'b0;
         in_xfer = 1'b0;
      end else if (in_xfer) begin
         if (!xfer_req || int'(xfer_len) != cur_chunk) bad_hold = 1'b1;
         if (wait_cnt == 0) begin
            xfer_done = 1'b1;
            exp_rem  -= cur_chunk;
            exp_base += cur_chunk;
            n_xfers++;
            wr_next = 0;
         end else begin
            wait_cnt--;
         end
      end else if (xfer_req) begin
         int mism;
         int first_bad;
         in_xfer = 1'b1;
         cur_chunk = (exp_rem < D) ? exp_rem : D;
         chk(int'(xfer_len) == cur_chunk, "R3 xfer_len", int'(xfer_len), cur_chunk);
         chk(wr_next == cur_chunk, "R2 slots filled", wr_next, cur_chunk);
         mism = 0;
         first_bad = -1;
         for (int k = 0; k < cur_chunk; k++) begin
            if (sbuf[k] !== pat(exp_base + k)) begin
               mism++;
               if (first_bad < 0) first_bad = k;
            end
         end
         chk(mism == 0, "R2 buffer content mismatches (first slot)", first_bad, -1);
         wait_cnt = $urandom_range(3, 0);
      end
   end

   task automatic run_cmd(input int addr, input int len, input bit spurious);
      int guard;
      lo_addr = addr;
      hi_addr = addr + len - 1;
      exp_rem = len;
      exp_base = addr;
      n_reads = 0;
      n_xfers = 0;
      wr_next = 0;
      bad_rd = 0; bad_gap = 0; bad_hold = 0; bad_ord = 0;
      @(negedge clk);
      cmd_start = 1'b1;
      cmd_addr = AW'(addr);
      cmd_len = LW'(len);
      @(negedge clk);
      cmd_start = 1'b0;
      cmd_addr = AW'($urandom);
      cmd_len = LW'($urandom);
      chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
      if (len == 0) chk(done == 1'b1, "R7 zero-length done next cycle", int'(done), 1);
      if (spurious) begin
         repeat (2) @(negedge clk);
         cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(done == 1'b1, "R4 command completes", int'(done), 1);
      chk(busy == 1'b1, "R10 busy in done cycle", int'(busy), 1);
      chk(n_reads == len, "R9 read count", n_reads, len);
      chk(!bad_rd, "R9 reads inside image", int'(bad_rd), 0);
      chk(n_xfers == (len + D - 1) / D, "R4 transfer count", n_xfers, (len + D - 1) / D);
      chk(exp_rem == 0, "R4 words left", exp_rem, 0);
      chk(!bad_gap, "R6 no fill while pending", int'(bad_gap), 0);
      chk(!bad_hold, "R5 request held", int'(bad_hold), 0);
      chk(!bad_ord, "R2 write order", int'(bad_ord), 0);
      if (spurious) chk(n_reads == len, "R8 start while busy ignored", n_reads, len);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
      chk(busy == 1'b0, "R10 idle after done", int'(busy), 0);
   endtask

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(xfer_req == 1'b0, "R1 xfer_req", int'(xfer_req), 0);
      chk(src_rd_en == 1'b0, "R1 src_rd_en", int'(src_rd_en), 0);
      chk(buf_wr_en == 1'b0, "R1 buf_wr_en", int'(buf_wr_en), 0);

      // R5: acknowledge while idle has no effect
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk(busy == 1'b0 && xfer_req == 1'b0, "R5 stray ack ignored", int'(busy), 0);

      // Directed corner cases
      run_cmd(100, 0, 1'b0);      // R7
      run_cmd(200, 1, 1'b0);
      run_cmd(300, D, 1'b0);      // exactly one full buffer
      run_cmd(400, D + 1, 1'b0);  // one word spills to a second pass
      run_cmd(500, D - 1, 1'b0);
      run_cmd(600, 2 * D, 1'b1);  // R8 spurious start
      run_cmd(65535 - 40, 40, 1'b0);

      // Random commands
      for (int n = 0; n < 40; n++) begin
         int a;
         int l;
         a = $urandom_range(4000, 0);
         l = $urandom_range(70, 0);
         run_cmd(a, l, (l > 0) && ($urandom_range(1, 0) == 1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule